// File: doc/BRIEF.md
# PRBS Bit Error Rate Counter Pair

This block measures the bit error rate of a received pseudo-random test pattern. It keeps two 8-bit counters. The error counter advances on each single-cycle pulse from an external pattern comparator. The time-base counter advances on each received CRC multiframe boundary. Software divides the error count by the elapsed multiframes to estimate the error rate.

Both counters are reached through a byte-wide port. Each register has its own write strobe and its own read strobe. Writing the error counter loads the written byte into it and zeroes the time base in the same cycle, so one write starts a fresh measurement window. The time base can also be loaded directly.

A sticky overflow flag records that the error counter wrapped. The flag drives an interrupt line through a mask bit. Reading the error counter clears the flag.

Top module: `prbs_ber_counters`

## Requirements
- R1: After reset both counters read 0x00, and the overflow flag and the interrupt are both 0.
- R2: The error counter increments by one in the cycle after each error strobe, and wraps from 0xFF to 0x00.
- R3: The time-base counter increments by one in the cycle after each multiframe strobe. It wraps from 0xFF to 0x00 without setting the overflow flag.
- R4: A write to the error counter loads the write data into it. In the same cycle it clears the time-base counter, and a multiframe strobe arriving in that cycle is ignored.
- R5: A write to the time-base counter loads the write data into it. When it coincides with a write to the error counter, the time-base load wins over the clear.
- R6: A write to a counter takes priority over an increment strobe for that same counter in the same cycle.
- R7: The overflow flag sets in the cycle after the error counter wraps from 0xFF to 0x00. It stays set until a read strobe of the error counter clears it. If a wrap and that read happen in the same cycle, the flag is set.
- R8: The interrupt output equals the overflow flag while the mask input is 0, and is 0 while the mask input is 1. The mask does not change the flag.
- R9: Read data shows the error counter when its read strobe is high, and the time-base counter when only that counter's read strobe is high. It shows 0x00 when no read strobe is high. Read data is combinational from the strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| err_strobe_i | input | 1 | One pulse per detected pattern bit error |
| mf_strobe_i | input | 1 | One pulse per received CRC multiframe |
| errcnt_wr_i | input | 1 | Write strobe, error counter |
| errcnt_rd_i | input | 1 | Read strobe, error counter (clears the overflow flag) |
| mfcnt_wr_i | input | 1 | Write strobe, time-base counter |
| mfcnt_rd_i | input | 1 | Read strobe, time-base counter |
| wdata_i | input | 8 | Write data |
| ovf_mask_i | input | 1 | 1 masks the overflow interrupt |
| rdata_o | output | 8 | Read data |
| ovf_flag_o | output | 1 | Sticky error-counter overflow flag |
| irq_o | output | 1 | Masked overflow interrupt |

## Verification
The bench first runs directed sequences:
- Plain strobe bursts and a wrap at 0xFF, which separate a correct increment from an off-by-one or saturating count.
- Same-cycle write/strobe collisions and a double write, which separate the write-over-increment priority from the load-over-clear priority.
- A wrap together with a flag-clearing read, and a wrap under mask, which separate set-wins from clear-wins, and a gated interrupt from a gated flag.

Long constrained-random runs follow. They set every strobe at once at several densities, and preload counters near 0xFF so that wraps are frequent. Each cycle is compared with a reference model built from the requirements.

// File: rtl/prbs_ber_pkg.sv
package prbs_ber_pkg;

   // Source selected onto the byte-wide read bus
   typedef enum logic [1:0] {
      RSEL_NONE = 2'd0,
      RSEL_ERR  = 2'd1,
      RSEL_MF   = 2'd2
   } rd_sel_e;

   // Error counter read has priority over time-base read
   function automatic rd_sel_e pick_source(input logic err_rd, input logic mf_rd);
      if (err_rd)     return RSEL_ERR;
      else if (mf_rd) return RSEL_MF;
      else            return RSEL_NONE;
   endfunction

endpackage

// File: rtl/ber_wrap_counter.sv
module ber_wrap_counter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   input  logic         clr_i,
   input  logic         inc_i,
   output logic [W-1:0] cnt_o,
   output logic         wrap_o
);

   localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
   localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

   initial begin
      assert (W >= 2) else $error("ber_wrap_counter: W must be at least 2");
   end

   logic [W-1:0] cnt_q;
   logic [W-1:0] cnt_d;
   logic         step_en;

   // Priority: load, then clear, then increment
   assign step_en = inc_i && !load_i && !clr_i;

   always_comb begin
      if (load_i)       cnt_d = load_val_i;
      else if (clr_i)   cnt_d = '0;
      else if (step_en) cnt_d = cnt_q + ONE;
      else              cnt_d = cnt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assign cnt_o  = cnt_q;
   assign wrap_o = step_en && (cnt_q == ALL_ONES);

   // R6, R5: a load always lands, whatever else is strobed
   a_r6_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> cnt_o == $past(load_val_i));

   // R2 and R3: an unobstructed strobe advances by exactly one
   a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !load_i && !clr_i) |=> cnt_o == $past(cnt_o) + ONE);

   // Idle cycles hold the count
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc_i && !load_i && !clr_i) |=> $stable(cnt_o));

endmodule

// File: rtl/ber_sticky_flag.sv
module ber_sticky_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);

   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_q <= 1'b0;
      else if (set_i) flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
   end

   assign flag_o = flag_q;

   a_r7_sets: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_o);

   a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !clr_i) |=> flag_o);

   a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_o && !set_i) |=> !flag_o);

endmodule

// File: rtl/ber_read_mux.sv
module ber_read_mux
   import prbs_ber_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 8
) (
   input  logic              err_rd_i,
   input  logic              mf_rd_i,
   input  logic [CNT_W-1:0]  err_val_i,
   input  logic [CNT_W-1:0]  mf_val_i,
   output logic [DATA_W-1:0] rdata_o
);

   localparam int PAD_W = DATA_W - CNT_W;

   rd_sel_e          sel;
   logic [CNT_W-1:0] picked;

   assign sel = pick_source(err_rd_i, mf_rd_i);

   always_comb begin
      unique case (sel)
         RSEL_ERR: picked = err_val_i;
         RSEL_MF:  picked = mf_val_i;
         default:  picked = '0;
      endcase
   end

   generate
      if (PAD_W > 0) begin : g_pad
         assign rdata_o = {{PAD_W{1'b0}}, picked};
      end else begin : g_exact
         assign rdata_o = picked;
      end
   endgenerate

   // R9: with no read strobe the bus is zero
   always_comb begin
      if (!err_rd_i && !mf_rd_i)
         a_r9_idle_zero: assert (rdata_o == '0);
   end

endmodule

// File: rtl/prbs_ber_counters.sv
module prbs_ber_counters #(
   parameter int CNT_W  = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              err_strobe_i,
   input  logic              mf_strobe_i,
   input  logic              errcnt_wr_i,
   input  logic              errcnt_rd_i,
   input  logic              mfcnt_wr_i,
   input  logic              mfcnt_rd_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              ovf_mask_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              ovf_flag_o,
   output logic              irq_o
);

   initial begin
      assert (CNT_W >= 2 && CNT_W <= DATA_W)
         else $error("prbs_ber_counters: need 2 <= CNT_W <= DATA_W");
   end

   logic [CNT_W-1:0] load_val;
   logic [CNT_W-1:0] err_cnt;
   logic [CNT_W-1:0] mf_cnt;
   logic             err_wrap;
   logic             mf_wrap;
   logic             flag;

   assign load_val = wdata_i[CNT_W-1:0];

   ber_wrap_counter #(.W(CNT_W)) u_err_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (errcnt_wr_i),
      .load_val_i (load_val),
      .clr_i      (1'b0),
      .inc_i      (err_strobe_i),
      .cnt_o      (err_cnt),
      .wrap_o     (err_wrap)
   );

   // Time base: cleared by an error-counter write, wraps silently
   ber_wrap_counter #(.W(CNT_W)) u_mf_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (mfcnt_wr_i),
      .load_val_i (load_val),
      .clr_i      (errcnt_wr_i),
      .inc_i      (mf_strobe_i),
      .cnt_o      (mf_cnt),
      .wrap_o     (mf_wrap)
   );

   ber_sticky_flag u_ovf (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (err_wrap),
      .clr_i  (errcnt_rd_i),
      .flag_o (flag)
   );

   ber_read_mux #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_rd (
      .err_rd_i  (errcnt_rd_i),
      .mf_rd_i   (mfcnt_rd_i),
      .err_val_i (err_cnt),
      .mf_val_i  (mf_cnt),
      .rdata_o   (rdata_o)
   );

   assign ovf_flag_o = flag;
   assign irq_o      = flag & ~ovf_mask_i;

   // R4: an error-counter write empties the time base unless it is loaded
   a_r4_mf_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (errcnt_wr_i && !mfcnt_wr_i) |=> mf_cnt == '0);

   // R7: a wrap of the error counter raises the flag
   a_r7_ovf_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (err_strobe_i && !errcnt_wr_i && (err_cnt == {CNT_W{1'b1}})) |=> ovf_flag_o);

   // R3: a time-base wrap alone never raises the flag
   a_r3_mf_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (mf_wrap && !err_wrap && !ovf_flag_o) |=> !ovf_flag_o);

endmodule

// File: tb/prbs_ber_counters_tb.sv
module prbs_ber_counters_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       err_strobe_i = 1'b0, mf_strobe_i = 1'b0;
   logic       errcnt_wr_i = 1'b0, errcnt_rd_i = 1'b0;
   logic       mfcnt_wr_i = 1'b0, mfcnt_rd_i = 1'b0;
   logic [7:0] wdata_i = 8'h00;
   logic       ovf_mask_i = 1'b0;
   logic [7:0] rdata_o;
   logic       ovf_flag_o, irq_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // reference state
   logic [7:0] m_err = 8'h00, m_mf = 8'h00;
   logic       m_flg = 1'b0;

   always #4 clk = ~clk;

   prbs_ber_counters dut_i (
      .clk(clk), .rst_n(rst_n),
      .err_strobe_i(err_strobe_i), .mf_strobe_i(mf_strobe_i),
      .errcnt_wr_i(errcnt_wr_i), .errcnt_rd_i(errcnt_rd_i),
      .mfcnt_wr_i(mfcnt_wr_i), .mfcnt_rd_i(mfcnt_rd_i),
      .wdata_i(wdata_i), .ovf_mask_i(ovf_mask_i),
      .rdata_o(rdata_o), .ovf_flag_o(ovf_flag_o), .irq_o(irq_o)
   );

   function automatic logic [7:0] exp_rdata(input bit er, input bit mr);
      if (er)      return m_err;
      else if (mr) return m_mf;
      else         return 8'h00;
   endfunction

   function automatic logic [7:0] nxt_err(input bit es, input bit ew, input logic [7:0] wd);
      if (ew)      return wd;
      else if (es) return m_err + 8'h01;
      else         return m_err;
   endfunction

   function automatic logic [7:0] nxt_mf(input bit ms, input bit ew, input bit mw, input logic [7:0] wd);
      if (mw)      return wd;
      else if (ew) return 8'h00;
      else if (ms) return m_mf + 8'h01;
      else         return m_mf;
   endfunction

   function automatic logic nxt_flg(input bit es, input bit ew, input bit er);
      if (es && !ew && m_err == 8'hFF) return 1'b1;
      else if (er)                     return 1'b0;
      else                             return m_flg;
   endfunction

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic step(input bit es, input bit ms, input bit ew, input bit er,
                       input bit mw, input bit mr, input logic [7:0] wd,
                       input bit mk, input string tag);
      @(negedge clk);
      err_strobe_i = es; mf_strobe_i = ms;
      errcnt_wr_i = ew;  errcnt_rd_i = er;
      mfcnt_wr_i = mw;   mfcnt_rd_i = mr;
      wdata_i = wd;      ovf_mask_i = mk;
      #1;
      check({tag, " rdata"}, rdata_o, exp_rdata(er, mr));
      check("R7 flag", {7'd0, ovf_flag_o}, {7'd0, m_flg});
      check("R8 irq", {7'd0, irq_o}, {7'd0, m_flg & ~mk});
      @(posedge clk);
      begin
         logic [7:0] ne, nm;
         logic       nf;
         ne = nxt_err(es, ew, wd);
         nm = nxt_mf(ms, ew, mw, wd);
         nf = nxt_flg(es, ew, er);
         m_err = ne; m_mf = nm; m_flg = nf;
      end
   endtask

   task automatic idle(input string tag);
      step(0, 0, 0, 0, 0, 0, 8'h00, 0, tag);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;

      // R1 reset state
      step(0, 0, 0, 1, 0, 0, 8'h00, 0, "R1 err after reset");
      step(0, 0, 0, 0, 0, 1, 8'h00, 0, "R1 mf after reset");
      check("R1 irq after reset", {7'd0, irq_o}, 8'h00);

      // R2 plain counting
      for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 0, 0, 8'h00, 0, "R2 count");
      step(0, 0, 0, 1, 0, 0, 8'h00, 0, "R2 five errors");

      // R2/R7 wrap from 0xFF
      step(0, 0, 1, 0, 0, 0, 8'hFE, 0, "R2 preload");
      step(1, 0, 0, 0, 0, 0, 8'h00, 0, "R2 to FF");
      step(1, 0, 0, 0, 0, 0, 8'h00, 0, "R2 wrap");
      idle("R7 flag after wrap");
      step(0, 0, 0, 1, 0, 0, 8'h00, 0, "R2 wrapped to 00");
      idle("R7 flag cleared by read");

      // R3 silent time-base wrap
      step(0, 0, 0, 0, 1, 0, 8'hFF, 0, "R5 mf load");
      step(0, 1, 0, 0, 0, 1, 8'h00, 0, "R5 mf loaded FF");
      step(0, 0, 0, 0, 0, 1, 8'h00, 0, "R3 mf wrapped");
      idle("R3 no flag from mf wrap");

      // R4/R6 error write against both strobes
      for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 0, 0, 8'h00, 0, "R3 count");
      step(1, 1, 1, 0, 0, 0, 8'h10, 0, "R6 write vs strobe");
      step(0, 0, 0, 1, 0, 0, 8'h00, 0, "R6 err took write");
      step(0, 0, 0, 0, 0, 1, 8'h00, 0, "R4 mf cleared");

      // R5 double write
      step(0, 1, 1, 0, 1, 0, 8'h33, 0, "R5 double write");
      step(0, 0, 0, 0, 0, 1, 8'h00, 0, "R5 mf load wins");
      step(0, 0, 0, 1, 0, 1, 8'h00, 0, "R9 both reads give err");
      idle("R9 no read gives 00");

      // R8 masked overflow
      step(0, 0, 1, 0, 0, 0, 8'hFF, 1, "R8 preload");
      step(1, 0, 0, 0, 0, 0, 8'h00, 1, "R8 wrap masked");
      step(0, 0, 0, 0, 0, 0, 8'h00, 1, "R8 masked irq low");
      step(0, 0, 0, 0, 0, 0, 8'h00, 0, "R8 unmasked irq high");

      // R7 set wins over clearing read
      step(0, 0, 1, 0, 0, 0, 8'hFF, 0, "R7 preload");
      step(1, 0, 0, 1, 0, 0, 8'h00, 0, "R7 wrap with read");
      idle("R7 set wins");
      step(0, 0, 0, 1, 0, 0, 8'h00, 0, "R7 clear");

      // random phase at several densities
      for (int phase = 0; phase < 4; phase++) begin
         for (int i = 0; i < 2500; i++) begin
            int unsigned thr;
            bit es, ms, ew, er, mw, mr, mk;
            logic [7:0] wd;
            thr = 20 + phase * 20;
            es = ($urandom % 100) < thr;
            ms = ($urandom % 100) < thr;
            ew = ($urandom % 100) < 3;
            mw = ($urandom % 100) < 3;
            er = ($urandom % 100) < 10;
            mr = ($urandom % 100) < 10;
            mk = ($urandom % 100) < 30;
            wd = (($urandom % 2) == 0) ? 8'(8'hF0 + ($urandom % 16)) : 8'($urandom);
            step(es, ms, ew, er, mw, mr, wd, mk, "R9 random");
         end
      end

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end

endmodule